// File: doc/BRIEF.md
# I2C Slave Register Read Engine

This block is an I2C target that gives bus access to a bank of 32 byte-wide registers held in an outside register file. SCL and SDA pass through two-flop synchronizers into the system clock. The system clock must run at least 8 times faster than SCL. The block detects START, repeated START and STOP, and it compares the 7-bit address against a parameter.

A write transaction loads a register pointer. A read transaction shifts out the byte at that pointer, MSB first, and moves the pointer on after each byte. The pointer goes back to zero after the last register. To read a chosen location, the master first writes the register address and then issues a repeated START with a read header. The outside register file sees the pointer on `rd_addr_o` and returns the byte on `rd_data_i` combinationally.

Top module: `i2c_reg_reader`

## Requirements
- R1: An address byte carries the 7-bit address in bits 7..1 and R/W in bit 0 (1 = read). The block pulls SDA low during the ninth clock only when the 7-bit address equals `SLAVE_ADDR`. On a mismatch it never drives SDA until the next START.
- R2: In a write, the byte after an acknowledged address is acknowledged. It loads the pointer with its value modulo 32, so the pointer is the low 5 bits of that byte.
- R3: In a read, the block sends the byte at the pointer right after the address acknowledge, MSB first. SDA changes only while SCL is low.
- R4: The pointer advances by one after every byte the block transmits, and `rd_addr_o` always shows the pointer. A read without a preceding write starts from the current pointer.
- R5: When the pointer advances from 31 it returns to 0, and the next byte comes from register 0.
- R6: When the master acknowledges a byte, the block sends the byte at the next address in the same transaction.
- R7: When the master does not acknowledge, the block releases SDA and sends nothing more until a new START. A STOP returns the block to idle with SDA released.
- R8: A repeated START begins a new address phase and keeps the pointer, so a write of the register address followed by a repeated START and a read header reads that register.
- R9: Bytes written after the register address are not acknowledged and leave the pointer unchanged.
- R10: After reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr_o | output | 5 | Register file read address (the pointer) |
| rd_data_i | input | 8 | Register file read data for `rd_addr_o` |

## Verification
The bench sets the pointer to 30 and reads across the end of the bank. A block that does not wrap would return register 32 or stall instead of register 0. It sends a second data byte after the register address and checks that this byte gets no acknowledge and leaves the pointer alone, since a careless design would acknowledge the byte and reload the pointer. A transaction to a foreign address is watched on every clock for any SDA drive, and a read that starts without a dummy write must continue from where the last read stopped. The NACK-then-STOP ending is followed by idle clocks in which SDA must stay released.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_A_ACK0, ST_A_ACK1, ST_REG, ST_R_ACK0, ST_R_ACK1,
    ST_TX, ST_TX_ACK, ST_WAIT
  } state_e;
endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] sync;
  logic [NLINES-1:0] prev;
  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain   <= '1;
        prev[l] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[l]};
        prev[l] <= chain[STAGES-1];
      end
    end
    assign sync[l] = chain[STAGES-1];
  end

  assign scl_o      = sync[1];
  assign sda_o      = sync[0];
  assign scl_rise_o = sync[1] & ~prev[1];
  assign scl_fall_o = ~sync[1] & prev[1];
  // data edges while clock held high
  assign start_o    = sync[1] & prev[1] & prev[0] & ~sync[0];
  assign stop_o     = sync[1] & prev[1] & ~prev[0] & sync[0];
endmodule

// File: rtl/i2c_rr_ptr.sv
module i2c_rr_ptr #(
  parameter int NUM_REGS = 32,
  parameter int PTR_W    = 6,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        load_val_i,
  input  logic              incr_i,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (load_i) begin
      ptr_o <= PTR_W'(load_val_i[ADDR_W-1:0]);
    end else if (incr_i) begin
      ptr_o <= (ptr_o >= LAST) ? '0 : ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rr_fsm.sv
module i2c_rr_fsm
  import i2c_rr_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [7:0]  rd_data_i,
  output logic        sda_oe_o,
  output logic        load_o,
  output logic [7:0]  load_val_o,
  output logic        incr_o,
  output state_e      state_o
);
  state_e     state_q;
  logic [2:0] cnt_q;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic       rw_q;
  logic       mack_q;

  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      load_o     <= 1'b0;
      load_val_o <= '0;
      incr_o     <= 1'b0;
    end else begin
      load_o <= 1'b0;
      incr_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        mack_q   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        mack_q   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            rx_q  <= {rx_q[5:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) begin
              rw_q    <= sda_i;
              state_q <= (rx_q == SLAVE_ADDR) ? ST_A_ACK0 : ST_WAIT;
            end
          end
          ST_A_ACK0: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            state_q  <= ST_A_ACK1;
          end
          ST_A_ACK1: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              state_q  <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_REG;
            end
          end
          ST_REG: if (scl_rise_i) begin
            rx_q  <= {rx_q[5:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) begin
              load_o     <= 1'b1;
              load_val_o <= {rx_q, sda_i};
              state_q    <= ST_R_ACK0;
            end
          end
          ST_R_ACK0: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            state_q  <= ST_R_ACK1;
          end
          ST_R_ACK1: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WAIT;   // further write data is refused
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              incr_o   <= 1'b1;
              state_q  <= ST_TX_ACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_o <= ~tx_q[6];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              if (sda_i) state_q <= ST_WAIT;
              else       mack_q  <= 1'b1;
            end else if (scl_fall_i && mack_q) begin
              mack_q   <= 1'b0;
              cnt_q    <= '0;
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              state_q  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_reader.sv
module i2c_reg_reader #(
  parameter logic [6:0] SLAVE_ADDR = 7'h48,
  parameter int NUM_REGS   = 32,
  parameter int PTR_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_incr;
  logic [7:0] ptr_load_val;
  logic [PTR_W-1:0] ptr_q;
  i2c_rr_pkg::state_e fsm_state;

  i2c_rr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rr_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) i_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .rd_data_i,
    .sda_oe_o, .load_o(ptr_load), .load_val_o(ptr_load_val), .incr_o(ptr_incr),
    .state_o(fsm_state)
  );

  i2c_rr_ptr #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .load_val_i(ptr_load_val),
    .incr_i(ptr_incr), .ptr_o(ptr_q)
  );

  assign rd_addr_o = ptr_q[ADDR_W-1:0];

  logic unused_scl_s;
  assign unused_scl_s = scl_s;
endmodule

// File: rtl/i2c_reg_reader_chk.sv
module i2c_reg_reader_chk
  import i2c_rr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int PTR_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] ptr_i,
  input logic             incr_i,
  input logic             stop_i,
  input state_e           st_i
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  a_r3_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r5_ptr_in_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i <= LAST);

  a_r4_ptr_steps_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incr_i |=> (ptr_i == (($past(ptr_i) == LAST) ? '0 : $past(ptr_i) + 1'b1)));

  a_r7_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);

  a_r1_silent_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE || st_i == ST_WAIT) |-> !sda_oe_o);
endmodule

bind i2c_reg_reader i2c_reg_reader_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .ptr_i(ptr_q), .incr_i(ptr_incr),
  .stop_i(stop_det), .st_i(fsm_state)
);

// File: tb/test_i2c_reg_reader.sv
`timescale 1ns/1ps
module test_i2c_reg_reader;
  localparam logic [6:0] SADDR = 7'h48;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic sda_bus;
  logic quiet = 1'b1;
  int n_chk = 0;
  int n_err = 0;
  logic ack_seen;
  logic [7:0] got;

  always #2 clk = ~clk;

  function automatic logic [7:0] reg_val(int i);
    return 8'((i * 29 + 7) % 256);
  endfunction

  assign sda_bus = m_sda & ~sda_oe;
  assign rd_data = reg_val(int'(rd_addr));

  i2c_reg_reader i_i2c_reg_reader (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model: slave must not drive while quiet
  always @(negedge clk) if (rst_n && quiet) begin
    n_chk++;
    if (sda_oe !== 1'b0) begin
      n_err++;
      $display("FAIL R1/R7 silent: actual=%0b expected=0", sda_oe);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    seen = sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  int exp_ptr;

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R10 reset state
    check("R10 sda released", int'(sda_oe), 0);
    check("R10 pointer zero", int'(rd_addr), 0);

    // dummy write then random read of 3 bytes
    quiet = 1'b0;
    do_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    check("R1 address ack", int'(ack_seen), 1);
    send_byte(8'h05, ack_seen);
    check("R2 register byte ack", int'(ack_seen), 1);
    check("R2 pointer loaded", int'(rd_addr), 5);
    do_start();
    send_byte({SADDR, 1'b1}, ack_seen);
    check("R8 read header ack", int'(ack_seen), 1);
    exp_ptr = 5;
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, got);
      check(k == 0 ? "R3 first byte" : "R6 next byte", int'(got), int'(reg_val(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % 32;
    end
    do_stop();
    quiet = 1'b1;
    tick(Q);
    check("R4 pointer advanced", int'(rd_addr), exp_ptr);

    // foreign address: whole transaction must stay silent
    do_start();
    send_byte({7'h22, 1'b0}, ack_seen);
    check("R1 mismatch no ack", int'(ack_seen), 0);
    send_byte(8'h10, ack_seen);
    check("R1 ignored byte no ack", int'(ack_seen), 0);
    check("R1 ignored pointer kept", int'(rd_addr), exp_ptr);
    do_start();
    send_byte({7'h49, 1'b1}, ack_seen);
    check("R1 mismatch read no ack", int'(ack_seen), 0);
    do_stop();
    tick(Q);

    // wrap: 0x3E modulo 32 = 0x1E
    quiet = 1'b0;
    do_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h3E, ack_seen);
    check("R2 modulo load", int'(rd_addr), 30);
    do_start();
    send_byte({SADDR, 1'b1}, ack_seen);
    exp_ptr = 30;
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, got);
      check(exp_ptr == 0 ? "R5 wrap to reg 0" : "R6 burst byte", int'(got), int'(reg_val(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % 32;
    end
    check("R7 released after nack", int'(sda_oe), 0);
    do_stop();
    quiet = 1'b1;
    tick(4 * Q);
    check("R5 pointer after wrap", int'(rd_addr), 2);

    // extra write data is refused
    quiet = 1'b0;
    do_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h09, ack_seen);
    check("R2 ack second load", int'(ack_seen), 1);
    quiet = 1'b1;
    send_byte(8'h11, ack_seen);
    check("R9 data byte no ack", int'(ack_seen), 0);
    check("R9 pointer unchanged", int'(rd_addr), 9);
    do_stop();
    tick(Q);

    // read without dummy write continues from pointer
    quiet = 1'b0;
    do_start();
    send_byte({SADDR, 1'b1}, ack_seen);
    check("R4 read header ack", int'(ack_seen), 1);
    recv_byte(1'b0, got);
    check("R4 current pointer byte", int'(got), int'(reg_val(9)));
    quiet = 1'b1;
    tick(2 * Q);
    do_stop();
    tick(Q);
    quiet = 1'b0;
    do_start();
    send_byte({SADDR, 1'b1}, ack_seen);
    recv_byte(1'b0, got);
    check("R4 following read", int'(got), int'(reg_val(10)));
    do_stop();
    quiet = 1'b1;
    tick(4 * Q);
    check("R7 idle after stop", int'(sda_oe), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule